// File: doc/BRIEF.md
# External Interrupt Input Sense Controller

This block watches six external interrupt pins and keeps one request flag for each of them. Every pin can be sensed by level or by edge, with a selectable active polarity. In edge sense, a pin can also be set to fire on both its rising and its falling edges. Each pin is first passed through a two-flop synchronizer. An edge is then found by comparing the synchronized sample with the one taken in the cycle before.

The block also steers two shared serial-port request lines. Each line carries the error event (bus collision, start/stop detect or framing fault) of one of two serial ports, and one select bit per line picks which port drives it. Software sets the block up through a byte-wide write port. Address 0 holds the cause byte. Address 1+i holds the control bits of pin i. Prioritisation and vectoring of the requests are left to the logic downstream.

Top module: `ext_irq_sense`

## Requirements
- R1: After reset, every stored bit is 0 and no request is raised: the cause byte, the per-pin control bits and all request flags. With the cause byte at 0, request line A follows the port-3 event and request line B follows the port-4 event.
- R2: Take a pin in edge sense with polarity 0 and its both-edges bit at 0. A falling edge on that pin sets its request, and a rising edge does not. The request becomes visible after the third rising clock edge that follows the pin change, and not after the second.
- R3: In edge sense with polarity 1 (control bit 0), a rising edge sets the request and a falling edge does not.
- R4: Setting cause-byte bit i to 1 makes pin i request on every rising edge and every falling edge. This holds whatever its polarity bit says, and it also holds when its level bit (control bit 1) is set.
- R5: In level sense (control bit 1 = 1, both-edges bit 0), the request follows the synchronized pin. It is active low when polarity is 0 and active high when polarity is 1. An acknowledge has no effect while the active level persists.
- R6: In edge sense, a set request stays set until an acknowledge pulse arrives on that pin's ack bit. That pulse clears the request at the next clock edge.
- R7: A write to address 1+i with data bit 2 set clears the edge-sense request of pin i.
- R8: Cause-byte bit 6 chooses the source of request line A: 0 selects the port-3 event and 1 selects the port-0 event.
- R9: Cause-byte bit 7 chooses the source of request line B: 0 selects the port-4 event and 1 selects the port-1 event.
- R10: A write that changes a pin's sense mode, polarity or both-edges bit does not, by itself, raise a request on that pin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0 cause byte, 1..6 pin control) |
| wr_data | input | 8 | Write data |
| pin_in | input | 6 | Asynchronous external interrupt pins |
| ack | input | 6 | Per-pin acknowledge pulses |
| ser0_evt | input | 1 | Serial port 0 error event |
| ser1_evt | input | 1 | Serial port 1 error event |
| ser3_evt | input | 1 | Serial port 3 error event |
| ser4_evt | input | 1 | Serial port 4 error event |
| irq_req | output | 6 | Per-pin request flags |
| ser_req_a | output | 1 | Shared request line A |
| ser_req_b | output | 1 | Shared request line B |

## Verification
A stale previous-sample register would show up three cycles after a pin change. The result is either a missing request or a spurious one, such as a request raised by a mode-changing write. A wrong mode decode shows up as a request on the wrong edge or on the wrong level, and this too becomes visible within three clocks. A broken sticky flag shows up differently: the request either drops without an acknowledge, or it survives an acknowledge, and either way this is visible one clock later.

// File: rtl/ext_irq_sense.sv
module ext_irq_sense #(
  parameter int N_IN = 6,
  parameter int AW   = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [7:0]      wr_data,
  input  logic [N_IN-1:0] pin_in,
  input  logic [N_IN-1:0] ack,
  input  logic            ser0_evt,
  input  logic            ser1_evt,
  input  logic            ser3_evt,
  input  logic            ser4_evt,
  output logic [N_IN-1:0] irq_req,
  output logic            ser_req_a,
  output logic            ser_req_b
);

  logic [7:0]      cause_q;
  logic [N_IN-1:0] pol_q, lvl_q, s1_q, s2_q, prev_q, req_q;
  logic [N_IN-1:0] both, lvl_eff, rise, fall, hit, active, clr_wr, mode_wr;

  wire sel_cause = wr_en && (wr_addr == '0);

  assign both    = cause_q[N_IN-1:0];
  assign lvl_eff = lvl_q & ~both;
  assign rise    = s2_q & ~prev_q;
  assign fall    = ~s2_q & prev_q;
  assign active  = ~(s2_q ^ pol_q);
  assign hit     = (both & (rise | fall)) | (~both & pol_q & rise) | (~both & ~pol_q & fall);

  for (genvar i = 0; i < N_IN; i++) begin : g_pin
    wire sel_ctrl = wr_en && (wr_addr == AW'(i + 1));
    assign clr_wr[i]  = sel_ctrl && wr_data[2];
    assign mode_wr[i] = (sel_cause && (wr_data[i] != cause_q[i])) ||
                        (sel_ctrl && (wr_data[1:0] != {lvl_q[i], pol_q[i]}));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pol_q[i] <= 1'b0;
        lvl_q[i] <= 1'b0;
        req_q[i] <= 1'b0;
      end else begin
        if (sel_ctrl) begin
          pol_q[i] <= wr_data[0];
          lvl_q[i] <= wr_data[1];
        end
        if (lvl_eff[i])                  req_q[i] <= active[i];
        else if (hit[i] && !mode_wr[i])  req_q[i] <= 1'b1;
        else if (ack[i] || clr_wr[i])    req_q[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q <= '0;
      s1_q    <= '0;
      s2_q    <= '0;
      prev_q  <= '0;
    end else begin
      if (sel_cause) cause_q <= wr_data;
      s1_q   <= pin_in;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  assign irq_req   = req_q;
  assign ser_req_a = cause_q[6] ? ser0_evt : ser3_evt;
  assign ser_req_b = cause_q[7] ? ser1_evt : ser4_evt;

endmodule

module ext_irq_sense_chk #(
  parameter int N_IN = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic [N_IN-1:0] irq_req,
  input logic [N_IN-1:0] ack,
  input logic [N_IN-1:0] lvl_eff,
  input logic [N_IN-1:0] pol,
  input logic [N_IN-1:0] s2,
  input logic [N_IN-1:0] prev,
  input logic [N_IN-1:0] clr_wr,
  input logic [N_IN-1:0] mode_wr,
  input logic            ser0_evt,
  input logic            ser1_evt,
  input logic            ser3_evt,
  input logic            ser4_evt,
  input logic            ser_req_a,
  input logic            ser_req_b
);

  a_r1_reset_clear: assert property (@(posedge clk) !rst_n |=> irq_req == '0);

  a_r8_line_a_source: assert property (@(posedge clk) disable iff (!rst_n)
    ser_req_a |-> (ser0_evt || ser3_evt));

  a_r9_line_b_source: assert property (@(posedge clk) disable iff (!rst_n)
    ser_req_b |-> (ser1_evt || ser4_evt));

  for (genvar i = 0; i < N_IN; i++) begin : g_chk
    a_r5_level_follow: assert property (@(posedge clk) disable iff (!rst_n)
      lvl_eff[i] |=> irq_req[i] == $past(s2[i] ~^ pol[i]));

    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req[i] && !lvl_eff[i] && !ack[i] && !clr_wr[i] && !mode_wr[i]) |=> irq_req[i]);

    a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_req[i] && !lvl_eff[i] && (s2[i] == prev[i])) |=> !irq_req[i]);
  end

endmodule

bind ext_irq_sense ext_irq_sense_chk #(.N_IN(N_IN)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .ack(ack),
  .lvl_eff(lvl_eff), .pol(pol_q), .s2(s2_q), .prev(prev_q),
  .clr_wr(clr_wr), .mode_wr(mode_wr),
  .ser0_evt(ser0_evt), .ser1_evt(ser1_evt), .ser3_evt(ser3_evt), .ser4_evt(ser4_evt),
  .ser_req_a(ser_req_a), .ser_req_b(ser_req_b)
);

// File: tb/ext_irq_sense_tb.sv
module ext_irq_sense_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [5:0] pin_in = 6'h3f;
  logic [5:0] ack = '0;
  logic       ser0_evt = 0, ser1_evt = 0, ser3_evt = 0, ser4_evt = 0;
  logic [5:0] irq_req;
  logic       ser_req_a, ser_req_b;
  int checks = 0, failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ext_irq_sense u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pin_in(pin_in), .ack(ack), .ser0_evt(ser0_evt), .ser1_evt(ser1_evt),
    .ser3_evt(ser3_evt), .ser4_evt(ser4_evt), .irq_req(irq_req),
    .ser_req_a(ser_req_a), .ser_req_b(ser_req_b)
  );

  // {both, level, polarity, pin_before, pin_after, expected request}
  localparam logic [5:0] VEC [12] = '{
    6'b000101, 6'b000010, 6'b001011, 6'b001100,
    6'b100011, 6'b100101, 6'b101101, 6'b110011,
    6'b010101, 6'b010010, 6'b011011, 6'b011100
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick(1);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic pulse_ack(input logic [5:0] m);
    ack = m;
    tick(1);
    ack = '0;
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    tick(200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    tick(3);
    check("R1 requests after reset", {2'b0, irq_req}, 8'h00);
    rst_n = 1'b1;
    tick(4);
    check("R1 no request after reset release", {2'b0, irq_req}, 8'h00);
    ser3_evt = 1'b1; ser4_evt = 1'b1; #1;
    check("R1 default line A source", {7'b0, ser_req_a}, 8'h01);
    check("R1 default line B source", {7'b0, ser_req_b}, 8'h01);
    ser3_evt = 1'b0; ser4_evt = 1'b0;

    foreach (VEC[k]) begin
      wr(3'd0, {7'b0, VEC[k][5]});
      wr(3'd1, {6'b0, VEC[k][4], VEC[k][3]});
      pin_in[0] = VEC[k][2];
      tick(5);
      pulse_ack(6'h01);
      tick(1);
      pin_in[0] = VEC[k][1];
      tick(5);
      check($sformatf("R2/R3/R4/R5 vector %0d", k), {7'b0, irq_req[0]}, {7'b0, VEC[k][0]});
    end
    wr(3'd0, 8'h00);
    wr(3'd1, 8'h04);
    pin_in[0] = 1'b1;
    tick(5);
    pulse_ack(6'h01);

    // R2 latency
    pin_in[4] = 1'b0;
    tick(2);
    check("R2 not yet after two edges", {7'b0, irq_req[4]}, 8'h00);
    tick(1);
    check("R2 request after third edge", {7'b0, irq_req[4]}, 8'h01);

    // R6 sticky then ack
    pin_in[4] = 1'b1;
    tick(10);
    check("R6 request held without ack", {7'b0, irq_req[4]}, 8'h01);
    pulse_ack(6'h10);
    check("R6 ack clears", {7'b0, irq_req[4]}, 8'h00);

    // R7 software clear
    pin_in[2] = 1'b0;
    tick(4);
    check("R7 request set before clear", {7'b0, irq_req[2]}, 8'h01);
    wr(3'd3, 8'h04);
    check("R7 write clears", {7'b0, irq_req[2]}, 8'h00);

    // R5 ack ignored while level active
    wr(3'd4, 8'h03);
    pin_in[3] = 1'b1;
    tick(4);
    pulse_ack(6'h08);
    check("R5 ack ignored in active level", {7'b0, irq_req[3]}, 8'h01);
    pin_in[3] = 1'b0;
    tick(4);
    check("R5 request drops with level", {7'b0, irq_req[3]}, 8'h00);

    // R10 mode writes raise nothing
    wr(3'd4, 8'h00);
    pulse_ack(6'h08);
    tick(2);
    wr(3'd4, 8'h01);
    tick(4);
    check("R10 polarity change no request", {7'b0, irq_req[3]}, 8'h00);
    wr(3'd0, 8'h08);
    tick(4);
    check("R10 both-edges change no request", {7'b0, irq_req[3]}, 8'h00);
    wr(3'd0, 8'h00);

    // R8 / R9 routing
    wr(3'd0, 8'h40);
    ser0_evt = 1'b1; #1;
    check("R8 port0 routed", {7'b0, ser_req_a}, 8'h01);
    ser0_evt = 1'b0; ser3_evt = 1'b1; #1;
    check("R8 port3 blocked", {7'b0, ser_req_a}, 8'h00);
    ser3_evt = 1'b0;
    wr(3'd0, 8'h80);
    ser1_evt = 1'b1; #1;
    check("R9 port1 routed", {7'b0, ser_req_b}, 8'h01);
    ser1_evt = 1'b0; ser4_evt = 1'b1; #1;
    check("R9 port4 blocked", {7'b0, ser_req_b}, 8'h00);
    ser4_evt = 1'b0;

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule